// File: doc/BRIEF.md
# Clock-Gear and Power-Mode Sequencer

This block decides how fast the CPU bus master runs and which power mode the chip is in. The system clock is never divided for peripherals. The CPU instead receives a clock-enable pulse, `cpu_en`. In high-speed mode this pulse is high on every system clock. In medium-speed mode it is high once every 2, 4, 8, 16 or 32 clocks. Because bus accesses are counted in CPU clock periods, a four-state access at divide-by-4 spans sixteen system clocks.

The block also sequences the low-power modes: sleep, software standby and hardware standby, plus a reset state. A new speed setting or a sleep request takes effect only on a clock where `bus_end` marks the close of the current bus cycle. The active divide ratio is kept while the chip sleeps or is in software standby, so a wake returns to the same speed mode. The hardware-standby pin, the reset pin and the watchdog overflow override everything else, in that order of priority.

Top module: `clkgear_pmc`

## Requirements
- R1: The speed code maps as follows: 0 gives no division, codes 1 to 5 divide by 2^code, and codes 6 and 7 saturate to divide-by-32. The active code appears on `gear`. While running at code g > 0, `cpu_en` is high for exactly one clock in every 2^g clocks. At code 0 it is high on every clock.
- R2: `spd_sel` is sampled only on a clock where `bus_end` is high while in high-speed or medium-speed mode. The new `gear` and `mode` appear after that edge. `bus_end` has no effect in any other mode.
- R3: After a change of gear, or a wake, `cpu_en` stays low and first goes high in the N-th clock after the switching edge (N is the new ratio). Ignored strobes do not disturb the pulse phase.
- R4: `periph_en` is high in high-speed, medium-speed and sleep modes, and low in every other mode.
- R5: From a run mode, `sleep_req` with `bus_end` high, `sw_stby_en`=0 and `lowspd_sel`=0 enters sleep (mode 2). In sleep, `cpu_en` is low and `periph_en` is high.
- R6: In sleep, `irq_wake` or `extirq_wake` returns the block to the run mode that matches the kept gear: high-speed (0) if gear is 0, otherwise medium-speed (1).
- R7: From a run mode, `sleep_req` with `bus_end` high, `sw_stby_en`=1, `lowspd_sel`=0 and `wdt_presel`=0 enters software standby (mode 3), with both enables low.
- R8: Software standby is left only on `extirq_wake`, which returns to the prior speed mode. `irq_wake` alone leaves the block in mode 3.
- R9: Any other sleep request is ignored and leaves mode, gear and pulse phase unchanged. This covers `lowspd_sel`=1, `sw_stby_en`=1 with `wdt_presel`=1, and any request without `bus_end`.
- R10: `res_pin_n` low or `wdt_ovf` high forces reset (mode 5) at the next edge, with gear 0 and both enables low. In the first clock in which both are inactive, the block moves to high-speed mode (0).
- R11: `hstby_pin_n` low forces hardware standby (mode 4) at the next edge, even while the reset inputs are active. Both enables are low in this mode. On release, the block passes through reset for one clock and then enters high-speed mode.
- R12: Mode codes are 0 high-speed, 1 medium-speed, 2 sleep, 3 software standby, 4 hardware standby and 5 reset. A synchronous low `rst_n` puts the block in reset with gear 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also used undivided by peripherals |
| rst_n | input | 1 | Synchronous active-low block reset |
| spd_sel | input | 3 | Requested speed code |
| sw_stby_en | input | 1 | Selects software standby on a sleep request |
| lowspd_sel | input | 1 | Low-speed request bit; when set, sleep requests are ignored |
| wdt_presel | input | 1 | Watchdog prescaler select; must be 0 for software standby |
| sleep_req | input | 1 | Sleep-instruction strobe |
| bus_end | input | 1 | Current bus cycle completes this clock |
| irq_wake | input | 1 | Interrupt wake request |
| extirq_wake | input | 1 | External interrupt wake request |
| res_pin_n | input | 1 | Reset pin, active low |
| wdt_ovf | input | 1 | Watchdog overflow |
| hstby_pin_n | input | 1 | Hardware standby pin, active low |
| mode | output | 3 | Current power mode code |
| gear | output | 3 | Active speed code (0..5) |
| cpu_en | output | 1 | CPU clock-enable pulse |
| periph_en | output | 1 | Peripheral clock enable |

## Verification
The embedded properties guard, on every clock, a fixed set of rules. Hardware standby takes priority over reset, and each reset source forces the reset state. The gear holds steady unless a bus cycle ends. Software standby ignores ordinary interrupts. After a gear switch, the enable pulses never occur back to back and no early pulse appears. The exact pulse phase needs the bench's cycle-by-cycle scenarios to show it: the first pulse lands on the N-th clock after a switch or a wake, and ignored strobes do not shift it. Those scenarios also show which run mode each wake path returns to, and how the code-6/7 saturation behaves.

// File: rtl/cgp_pkg.sv
// Package: shared power-mode encoding and speed-code helper for the clock-gear block.
package cgp_pkg;

    // Power-mode codes; values are visible on the top-level mode port.
    typedef enum logic [2:0] {
        PM_HIGH  = 3'd0,
        PM_MED   = 3'd1,
        PM_SLEEP = 3'd2,
        PM_SSTBY = 3'd3,
        PM_HSTBY = 3'd4,
        PM_RESET = 3'd5
    } pmode_t;

    // Clamp a requested speed code to the deepest supported divide shift.
    function automatic int unsigned sat_gear(input int unsigned sel, input int unsigned max_shift);
        return (sel > max_shift) ? max_shift : sel;
    endfunction

endpackage

// File: rtl/cg_mode_fsm.sv
// Module: cg_mode_fsm
// Holds the power mode and the active gear. Forced inputs are resolved first,
// in the order hardware standby, then reset sources; after that come wake and
// sleep/speed transitions. Run-mode changes occur only on bus_end.
// Assumes all inputs are synchronous to clk.
module cg_mode_fsm
    import cgp_pkg::*;
#(
    parameter int MAX_SHIFT = 5,
    parameter int SEL_W     = 3,
    localparam int GW       = $clog2(MAX_SHIFT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] spd_sel,
    input  logic             sw_stby_en,
    input  logic             lowspd_sel,
    input  logic             wdt_presel,
    input  logic             sleep_req,
    input  logic             bus_end,
    input  logic             irq_wake,
    input  logic             extirq_wake,
    input  logic             res_pin_n,
    input  logic             wdt_ovf,
    input  logic             hstby_pin_n,
    output pmode_t           mode_o,
    output logic [GW-1:0]    gear_o,
    output logic             load_o
);

    pmode_t        mode_q, mode_d;
    logic [GW-1:0] gear_q, gear_d;
    pmode_t        speed_mode;

    // Next-state selection with fixed priority.
    always_comb begin
        mode_d     = mode_q;
        gear_d     = gear_q;
        speed_mode = (gear_q == '0) ? PM_HIGH : PM_MED;
        if (!hstby_pin_n) begin
            mode_d = PM_HSTBY;
            gear_d = '0;
        end else if (!res_pin_n || wdt_ovf) begin
            mode_d = PM_RESET;
            gear_d = '0;
        end else begin
            case (mode_q)
                PM_HSTBY: mode_d = PM_RESET;
                PM_RESET: mode_d = PM_HIGH;
                PM_SLEEP: if (irq_wake || extirq_wake) mode_d = speed_mode;
                PM_SSTBY: if (extirq_wake) mode_d = speed_mode;
                default: begin
                    if (bus_end) begin
                        if (sleep_req) begin
                            if (!sw_stby_en && !lowspd_sel)
                                mode_d = PM_SLEEP;
                            else if (sw_stby_en && !lowspd_sel && !wdt_presel)
                                mode_d = PM_SSTBY;
                        end else begin
                            gear_d = GW'(sat_gear(32'(spd_sel), MAX_SHIFT));
                            mode_d = (gear_d == '0) ? PM_HIGH : PM_MED;
                        end
                    end
                end
            endcase
        end
    end

    // State registers with synchronous reset into the reset mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= PM_RESET;
            gear_q <= '0;
        end else begin
            mode_q <= mode_d;
            gear_q <= gear_d;
        end
    end

    // Tell the divider that its phase must restart at this edge.
    assign load_o = (mode_d != mode_q) || (gear_d != gear_q);
    assign mode_o = mode_q;
    assign gear_o = gear_q;

    AST_HSTBY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        !hstby_pin_n |=> mode_q == PM_HSTBY); // R11
    AST_RESET_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        hstby_pin_n && (!res_pin_n || wdt_ovf) |=> mode_q == PM_RESET); // R10
    AST_GEAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        hstby_pin_n && res_pin_n && !wdt_ovf && !bus_end |=> $stable(gear_q)); // R2
    AST_SSTBY_STAY: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q == PM_SSTBY && !extirq_wake && hstby_pin_n && res_pin_n && !wdt_ovf
        |=> mode_q == PM_SSTBY); // R8

endmodule

// File: rtl/cg_divider.sv
// Module: cg_divider
// Produces the CPU clock-enable pulse: one clock high every 2^gear clocks.
// The phase counter restarts at every load so no shortened period appears.
// Assumes gear_i never exceeds MAX_SHIFT.
module cg_divider #(
    parameter int MAX_SHIFT = 5,
    localparam int GW       = $clog2(MAX_SHIFT + 1),
    localparam int CW       = (MAX_SHIFT > 0) ? MAX_SHIFT : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic [GW-1:0] gear_i,
    input  logic          load_i,
    output logic          cpu_en_o
);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] wrap;

    // Terminal count for the current ratio.
    always_comb wrap = ~({CW{1'b1}} << gear_i);

    // Phase counter: cleared on load or when not running, wraps at terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i || !run_i)
            cnt_q <= '0;
        else if (cnt_q == wrap)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign cpu_en_o = run_i && (cnt_q == wrap);

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_en_o && gear_i != '0 && !load_i |=> !cpu_en_o); // R1
    AST_NO_SHORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (!cpu_en_o || gear_i == '0)); // R3

endmodule

// File: rtl/cg_gate.sv
// Module: cg_gate
// Decodes the power mode into the run flag and the peripheral clock enable.
// Purely combinational.
module cg_gate
    import cgp_pkg::*;
(
    input  pmode_t mode_i,
    output logic   run_o,
    output logic   periph_en_o
);

    // Run modes clock the CPU; sleep additionally keeps peripherals alive.
    always_comb begin
        run_o       = (mode_i == PM_HIGH) || (mode_i == PM_MED);
        periph_en_o = run_o || (mode_i == PM_SLEEP);
    end

endmodule

// File: rtl/clkgear_pmc.sv
// Module: clkgear_pmc (top)
// Clock-gear and power-mode sequencer. Wires the mode machine, the gear
// divider and the enable decoder. Assumes synchronous inputs on clk.
module clkgear_pmc
    import cgp_pkg::*;
#(
    parameter int MAX_SHIFT = 5,
    parameter int SEL_W     = 3,
    localparam int GW       = $clog2(MAX_SHIFT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] spd_sel,
    input  logic             sw_stby_en,
    input  logic             lowspd_sel,
    input  logic             wdt_presel,
    input  logic             sleep_req,
    input  logic             bus_end,
    input  logic             irq_wake,
    input  logic             extirq_wake,
    input  logic             res_pin_n,
    input  logic             wdt_ovf,
    input  logic             hstby_pin_n,
    output logic [2:0]       mode,
    output logic [GW-1:0]    gear,
    output logic             cpu_en,
    output logic             periph_en
);

    pmode_t        mode_w;
    logic [GW-1:0] gear_w;
    logic          load_w;
    logic          run_w;

    cg_mode_fsm #(.MAX_SHIFT(MAX_SHIFT), .SEL_W(SEL_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .spd_sel(spd_sel), .sw_stby_en(sw_stby_en),
        .lowspd_sel(lowspd_sel), .wdt_presel(wdt_presel), .sleep_req(sleep_req),
        .bus_end(bus_end), .irq_wake(irq_wake), .extirq_wake(extirq_wake),
        .res_pin_n(res_pin_n), .wdt_ovf(wdt_ovf), .hstby_pin_n(hstby_pin_n),
        .mode_o(mode_w), .gear_o(gear_w), .load_o(load_w)
    );

    cg_gate u_gate (
        .mode_i(mode_w), .run_o(run_w), .periph_en_o(periph_en)
    );

    cg_divider #(.MAX_SHIFT(MAX_SHIFT)) u_div (
        .clk(clk), .rst_n(rst_n), .run_i(run_w), .gear_i(gear_w),
        .load_i(load_w), .cpu_en_o(cpu_en)
    );

    assign mode = mode_w;
    assign gear = gear_w;

    AST_SLEEP_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        mode_w == PM_SLEEP |-> periph_en && !cpu_en); // R5

endmodule

// File: tb/clkgear_pmc_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected {mode,gear,cpu_en,periph_en}
// items tagged with the target cycle; the monitor pops and compares them.
module clkgear_pmc_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] spd_sel = '0;
    logic       sw_stby_en = 0, lowspd_sel = 0, wdt_presel = 0;
    logic       sleep_req = 0, bus_end = 0, irq_wake = 0, extirq_wake = 0;
    logic       res_pin_n = 1, wdt_ovf = 0, hstby_pin_n = 1;
    logic [2:0] mode, gear;
    logic       cpu_en, periph_en;

    int total = 0;
    int bad   = 0;
    int cyc_n = 0;
    int    q_at[$];
    logic [7:0] q_val[$];
    string q_tag[$];

    always #2 clk = ~clk;

    clkgear_pmc uut (
        .clk(clk), .rst_n(rst_n), .spd_sel(spd_sel), .sw_stby_en(sw_stby_en),
        .lowspd_sel(lowspd_sel), .wdt_presel(wdt_presel), .sleep_req(sleep_req),
        .bus_end(bus_end), .irq_wake(irq_wake), .extirq_wake(extirq_wake),
        .res_pin_n(res_pin_n), .wdt_ovf(wdt_ovf), .hstby_pin_n(hstby_pin_n),
        .mode(mode), .gear(gear), .cpu_en(cpu_en), .periph_en(periph_en)
    );

    function automatic logic [7:0] pk(input int m, input int g, input bit c, input bit p);
        return {m[2:0], g[2:0], c, p};
    endfunction

    task automatic nxt();
        @(negedge clk);
    endtask

    // Expectation for the outputs after the coming rising edge.
    task automatic exp(input logic [7:0] v, input string tag);
        q_at.push_back(cyc_n + 1);
        q_val.push_back(v);
        q_tag.push_back(tag);
    endtask

    // Monitor: sample 1 ns after each rising edge and compare due items.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc_n++;
            while (q_at.size() > 0 && q_at[0] == cyc_n) begin
                logic [7:0] act, ev;
                string t;
                void'(q_at.pop_front());
                ev  = q_val.pop_front();
                t   = q_tag.pop_front();
                act = {mode, gear, cpu_en, periph_en};
                total++;
                if (act !== ev) begin
                    bad++;
                    $display("FAIL %s cycle=%0d actual=%h expected=%h", t, cyc_n, act, ev);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        nxt(); exp(pk(5,0,0,0), "R12 reset state");
        nxt(); rst_n = 1; exp(pk(0,0,1,1), "R10 exit to high after reset");
        // R2: request pending without bus_end
        nxt(); spd_sel = 3'd2; exp(pk(0,0,1,1), "R2 no bus_end");
        nxt(); exp(pk(0,0,1,1), "R2 still pending");
        nxt(); bus_end = 1; exp(pk(1,2,0,1), "R2 applied at bus_end");
        for (int i = 2; i <= 8; i++) begin
            nxt(); bus_end = 0; exp(pk(1,2,(i % 4) == 0,1), "R3 div4 phase R1");
        end
        // R9: ignored sleep requests keep mode and phase
        nxt(); sleep_req = 1; lowspd_sel = 1; bus_end = 1; exp(pk(1,2,0,1), "R9 lowspd set");
        nxt(); lowspd_sel = 0; sw_stby_en = 1; wdt_presel = 1; exp(pk(1,2,0,1), "R9 presel set");
        nxt(); sw_stby_en = 0; wdt_presel = 0; bus_end = 0; exp(pk(1,2,0,1), "R9 no bus_end");
        nxt(); sleep_req = 0; exp(pk(1,2,1,1), "R9 phase kept R1");
        // Sleep and interrupt wake
        nxt(); sleep_req = 1; bus_end = 1; exp(pk(2,2,0,1), "R5 sleep entry R4");
        nxt(); sleep_req = 0; bus_end = 0; exp(pk(2,2,0,1), "R5 sleep held");
        nxt(); spd_sel = 3'd5; bus_end = 1; exp(pk(2,2,0,1), "R2 bus_end ignored in sleep");
        nxt(); bus_end = 0; irq_wake = 1; exp(pk(1,2,0,1), "R6 wake to medium");
        for (int i = 2; i <= 4; i++) begin
            nxt(); irq_wake = 0; exp(pk(1,2,i == 4,1), "R3 phase after wake");
        end
        // Software standby
        nxt(); spd_sel = 3'd2; sw_stby_en = 1; sleep_req = 1; bus_end = 1;
        exp(pk(3,2,0,0), "R7 standby entry");
        nxt(); sleep_req = 0; bus_end = 0; irq_wake = 1; exp(pk(3,2,0,0), "R8 irq ignored");
        nxt(); irq_wake = 0; extirq_wake = 1; exp(pk(1,2,0,1), "R8 external wake");
        nxt(); extirq_wake = 0; sw_stby_en = 0; exp(pk(1,2,0,1), "R8 after wake");
        // Code 7 saturates to divide-by-32
        nxt(); spd_sel = 3'd7; bus_end = 1; exp(pk(1,5,0,1), "R1 code7 saturates");
        for (int i = 2; i <= 33; i++) begin
            nxt(); bus_end = 0; exp(pk(1,5,i == 32,1), "R3 div32 phase");
        end
        // Back to high speed, sleep from high, wake to high
        nxt(); spd_sel = 3'd0; bus_end = 1; exp(pk(0,0,1,1), "R1 undivided");
        nxt(); bus_end = 0; exp(pk(0,0,1,1), "R1 undivided held");
        nxt(); sleep_req = 1; bus_end = 1; exp(pk(2,0,0,1), "R5 sleep from high");
        nxt(); sleep_req = 0; bus_end = 0; extirq_wake = 1; exp(pk(0,0,1,1), "R6 wake to high");
        // Divide-by-2
        nxt(); extirq_wake = 0; spd_sel = 3'd1; bus_end = 1; exp(pk(1,1,0,1), "R1 div2 switch");
        nxt(); bus_end = 0; exp(pk(1,1,1,1), "R1 div2 pulse");
        nxt(); exp(pk(1,1,0,1), "R1 div2 gap");
        nxt(); exp(pk(1,1,1,1), "R1 div2 pulse again");
        // Reset pin
        nxt(); res_pin_n = 0; exp(pk(5,0,0,0), "R10 reset pin");
        nxt(); exp(pk(5,0,0,0), "R10 reset held");
        nxt(); res_pin_n = 1; exp(pk(0,0,1,1), "R10 reset release");
        // Watchdog overflow
        nxt(); spd_sel = 3'd3; bus_end = 1; exp(pk(1,3,0,1), "R1 div8 switch");
        nxt(); bus_end = 0; wdt_ovf = 1; exp(pk(5,0,0,0), "R10 watchdog");
        nxt(); wdt_ovf = 0; exp(pk(0,0,1,1), "R10 watchdog release");
        // Hardware standby wins over reset
        nxt(); bus_end = 1; exp(pk(1,3,0,1), "R1 div8 again");
        nxt(); bus_end = 0; hstby_pin_n = 0; res_pin_n = 0; exp(pk(4,0,0,0), "R11 priority over reset");
        nxt(); res_pin_n = 1; exp(pk(4,0,0,0), "R11 held R4");
        nxt(); hstby_pin_n = 1; exp(pk(5,0,0,0), "R11 exit through reset");
        nxt(); exp(pk(0,0,1,1), "R11 then high speed");
        repeat (3) nxt();
        total++;
        if (q_at.size() != 0) begin
            bad++;
            $display("FAIL scoreboard R12 actual=%0d expected=0 pending", q_at.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule